// File: doc/BRIEF.md
# Reset-Time Strap Sampler

This block reads the start-up configuration of a chip from the levels on its 16 port pins while the system reset is held. During reset it sets the port to input and turns on weak pull-ups. A pin left open therefore reads high and selects the default setting. A pin tied low through an external resistor selects the non-default setting. On every clock of reset the pin levels pass through a synchronizer, and the synchronized sample is held in a capture register.

When reset is released, the capture register freezes and keeps its value until the next reset. The lower pins become the bus-configuration value. The upper pins become a read-only high-byte configuration value that software can inspect to learn the chip-select count and the segment address selection. One clock later the block drops the pull-ups and the direction override, so the port is handed to its operating mode. On the same edge it raises a configuration-valid flag.

The reset input is synchronous and active high. It is the system reset whose release marks the end of strap sampling.

Top module: `strap_sampler`

## Requirements
- R1: On the clock edge after any edge with `rst` high, `pullup_en_o` and `dir_in_o` are both 1.
- R2: `cfg_valid_o` is 0 after every edge with `rst` high. It is 1 after the first edge with `rst` low, and it stays 1 until `rst` is sampled high again.
- R3: After any edge with `rst` low, `pullup_en_o` and `dir_in_o` are 0. They are never 1 while `cfg_valid_o` is 1.
- R4: While `cfg_valid_o` is 1, `buscfg_o` equals bits [LO_W-1:0] of `pin_i` as sampled SYNC_STAGES edges before the last edge at which `rst` was high. With the defaults, this is the pin level two edges before that last reset edge. Pin changes that arrive later are not captured.
- R5: While `cfg_valid_o` is 1, `hiconf_o` equals bits [PIN_W-1:PIN_W-HI_W] of `pin_i`, sampled at the same edge as in R4.
- R6: Each pin maps to its own output bit. A pin held high gives a 1, which is the default setting, and a pin held low gives a 0. With all pins high, the outputs are all ones.
- R7: While `cfg_valid_o` is 1, changes on `pin_i` do not change `buscfg_o` or `hiconf_o`.
- R8: Asserting `rst` again after operation restarts sampling. `cfg_valid_o` drops, the pull-ups come back on, and the next release freezes the new pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset; the strap sampling window |
| pin_i | input | PIN_W | Port pin levels |
| pullup_en_o | output | 1 | Enables the pin pull-ups |
| dir_in_o | output | 1 | Forces all port lines to input |
| buscfg_o | output | LO_W | Frozen bus-configuration value (lower pins) |
| hiconf_o | output | HI_W | Read-only frozen high-byte configuration |
| cfg_valid_o | output | 1 | Captured configuration is frozen and valid |

## Verification
The bench uses the default parameters: PIN_W=16, HI_W=8 and SYNC_STAGES=2. With these values, a walking-zero sweep covers every one of the sixteen pin-to-bit mappings within a few hundred cycles. The short two-stage latency also lets the bench set up both sides of the capture boundary exactly. In one case a new pin level is present for only the final two reset edges and must not be captured. In the other it is present for three edges and must be captured. The bench also repeats reset in the middle of operation and toggles the pins freely after release, to show that the frozen values cannot be disturbed.

// File: rtl/strap_pkg.sv
package strap_pkg;

    // Port phase: straps being sampled, or port handed to operation
    typedef enum logic {
        PH_STRAP = 1'b0,
        PH_RUN   = 1'b1
    } phase_e;

    function automatic logic phase_is_strap(input phase_e ph);
        return ph == PH_STRAP;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // No reset: the chain must keep sampling while reset is held
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int PIN_W = 16,
    parameter int HI_W  = 8,
    localparam int LO_W = PIN_W - HI_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] d,
    output logic [LO_W-1:0]  lo_q,
    output logic [HI_W-1:0]  hi_q
);
    logic [PIN_W-1:0] cap_q;

    // Tracks the synchronized pins during reset, frozen afterwards
    always_ff @(posedge clk) begin
        if (rst) cap_q <= d;
    end

    assign lo_q = cap_q[LO_W-1:0];
    assign hi_q = cap_q[PIN_W-1:LO_W];
endmodule

// File: rtl/strap_ctrl.sv
module strap_ctrl
    import strap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic pullup_en,
    output logic dir_in,
    output logic valid
);
    phase_e phase_q;
    logic   valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_STRAP;
            valid_q <= 1'b0;
        end else begin
            phase_q <= PH_RUN;
            valid_q <= 1'b1;
        end
    end

    assign pullup_en = phase_is_strap(phase_q);
    assign dir_in    = phase_is_strap(phase_q);
    assign valid     = valid_q;

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> valid_q); // R2

    AST_NO_PULLUP_WHEN_VALID: assert property (@(posedge clk) disable iff (rst)
        !(valid_q && pullup_en)); // R3
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler #(
    parameter int PIN_W       = 16,
    parameter int HI_W        = 8,
    parameter int SYNC_STAGES = 2,
    localparam int LO_W       = PIN_W - HI_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] pin_i,
    output logic             pullup_en_o,
    output logic             dir_in_o,
    output logic [LO_W-1:0]  buscfg_o,
    output logic [HI_W-1:0]  hiconf_o,
    output logic             cfg_valid_o
);
    logic [PIN_W-1:0] pin_sync;

    strap_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_i),
        .q   (pin_sync)
    );

    strap_capture #(.PIN_W(PIN_W), .HI_W(HI_W)) u_cap (
        .clk  (clk),
        .rst  (rst),
        .d    (pin_sync),
        .lo_q (buscfg_o),
        .hi_q (hiconf_o)
    );

    strap_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pullup_en (pullup_en_o),
        .dir_in    (dir_in_o),
        .valid     (cfg_valid_o)
    );

    AST_FROZEN_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        cfg_valid_o |=> ($stable(buscfg_o) && $stable(hiconf_o))); // R7

    AST_VALID_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        pullup_en_o |=> cfg_valid_o); // R2
endmodule

// File: tb/strap_sampler_test.sv
`timescale 1ns/1ps
module strap_sampler_test;
    localparam int PIN_W = 16;
    localparam int HI_W  = 8;
    localparam int STG   = 2;
    localparam int LO_W  = PIN_W - HI_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [PIN_W-1:0] pin = '1;
    logic             pullup_en_o, dir_in_o, cfg_valid_o;
    logic [LO_W-1:0]  buscfg_o;
    logic [HI_W-1:0]  hiconf_o;

    strap_sampler #(.PIN_W(PIN_W), .HI_W(HI_W), .SYNC_STAGES(STG)) uut (
        .clk(clk), .rst(rst), .pin_i(pin),
        .pullup_en_o(pullup_en_o), .dir_in_o(dir_in_o),
        .buscfg_o(buscfg_o), .hiconf_o(hiconf_o), .cfg_valid_o(cfg_valid_o)
    );

    always #2 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 0;
    string phase_req = "R6";

    // Behavioural reference: pin history queue, expected flags
    logic [PIN_W-1:0] hist[$];
    logic [PIN_W-1:0] exp_cap;
    bit               exp_strap, exp_valid, known, cap_known;

    always @(posedge clk) begin
        cycles++;
        hist.push_back(pin);
        if (hist.size() > STG + 1) void'(hist.pop_front());
        known = 1;
        if (rst) begin
            exp_strap = 1;
            exp_valid = 0;
            if (hist.size() == STG + 1) begin
                exp_cap   = hist[0];
                cap_known = 1;
            end else begin
                cap_known = 0;
            end
        end else begin
            exp_strap = 0;
            exp_valid = 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        if (known && !done) begin
            chk(exp_strap ? "R1 pullup" : "R3 pullup", 32'(pullup_en_o), 32'(exp_strap));
            chk(exp_strap ? "R1 dir" : "R3 dir", 32'(dir_in_o), 32'(exp_strap));
            chk("R2 valid", 32'(cfg_valid_o), 32'(exp_valid));
            if (exp_valid && cap_known) begin
                chk({"R4 buscfg ", phase_req}, 32'(buscfg_o), 32'(exp_cap[LO_W-1:0]));
                chk({"R5 hiconf ", phase_req}, 32'(hiconf_o), 32'(exp_cap[PIN_W-1:LO_W]));
            end
        end
    end

    task automatic step(input logic r, input logic [PIN_W-1:0] p, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst = r;
            pin = p;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        // R6: open pins (all high) give the all-ones default
        phase_req = "R6";
        step(1, '1, 6);
        step(0, '1, 5);
        // R7: pin activity after release must not move the outputs
        phase_req = "R7";
        for (int i = 0; i < 20; i++) step(0, PIN_W'(16'h1357 * (i + 3)), 1);
        // R8: reset again mid-operation with a mixed pattern
        phase_req = "R8";
        step(1, 16'hA53C, 6);
        step(0, 16'h0000, 6);
        // R4 boundary: new level present only at the last two reset edges
        phase_req = "R4";
        step(1, 16'h5AC3, 6);
        step(1, 16'h0F0F, 2);
        step(0, 16'h0F0F, 4);
        // R4 boundary: new level present at the last three reset edges
        step(1, 16'h5AC3, 6);
        step(1, 16'hF00F, 3);
        step(0, 16'hF00F, 4);
        // R6: walking zero, each line maps to its own bit
        phase_req = "R6";
        for (int b = 0; b < PIN_W; b++) begin
            step(1, ~(PIN_W'(1) << b), 5);
            step(0, '1, 3);
        end
        step(0, 16'h0000, 3);
        finish_run();
    end
endmodule